// File: doc/BRIEF.md
# Oversampling Serial Receive Engine

This block turns an asynchronous serial line into parallel bytes. It advances on a single-cycle enable that pulses at sixteen times the bit rate. While idle, it watches the line for a low level. It confirms a start bit at that bit's midpoint, then samples every later bit at its centre. It assembles a word of 5 to 8 bits, checks an optional parity bit, and samples one or two stop bits.

Software sets the frame format through a six-bit line-control input, and may change it between frames. The engine captures the format when a frame begins. A finished word goes into a holding register. A five-bit status output flags new data, overrun, parity error, framing error and a break condition. A one-cycle data-read strobe and a one-cycle status-read strobe clear the corresponding flags.

Top module: `uart_rx_engine`

## Requirements
- R1: After synchronous reset, `rx_data` is 0x00 and `rx_status` is 0x00, and the engine waits idle for a low line.
- R2: A start is detected on the first `tick` that sees the synchronised line low. If the line is high on the 8th `tick` after detection, the start is rejected. No byte is produced, and the status stays unchanged.
- R3: Data bits are sampled only on `tick` pulses, least significant bit first. Sampling begins 24 ticks after start detection and repeats every 16 ticks. This holds whatever the spacing of `tick` pulses in clock cycles.
- R4: `lcr[1:0]` selects the word length (00=5, 01=6, 10=7, 11=8 bits). Shorter words appear zero-extended in `rx_data`.
- R5: `lcr[3]=1` adds a parity bit after the data, and `lcr[4]=1` selects even parity (0 selects odd). With `lcr[5]=1` (stick), the parity bit must be 0 when `lcr[4]=1` and 1 when `lcr[4]=0`. A mismatch sets `rx_status[2]`.
- R6: `lcr[2]=0` gives one stop bit and `lcr[2]=1` gives two. A low first stop sample sets the framing flag `rx_status[3]`.
- R7: When every data, parity and stop sample of a frame is low, the break flag `rx_status[4]` is set together with the framing flag. The engine then waits for the line to return high before it accepts a new start.
- R8: A completed frame loads `rx_data` and sets data-ready `rx_status[0]`. A `rd_data` pulse clears data-ready.
- R9: If a frame completes while data-ready is still set and is not being read, overrun `rx_status[1]` is set. The new byte replaces the old one.
- R10: A `rd_status` pulse clears bits 4..1 of `rx_status` and leaves data-ready unchanged. Flags from a frame completing in the same cycle survive.
- R11: If `rd_data` coincides with frame completion, the new byte is loaded, data-ready stays set, and no overrun is flagged.
- R12: The format is captured at start detection. Changing `lcr` during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oversample enable, 16 pulses per bit period |
| rxd | input | 1 | Serial input line, idle high |
| lcr | input | 6 | Frame format: [1:0] length, [2] two stops, [3] parity on, [4] even, [5] stick |
| rd_data | input | 1 | One-cycle strobe: holding register is being read |
| rd_status | input | 1 | One-cycle strobe: status is being read |
| rx_data | output | 8 | Holding register, zero-extended received word |
| rx_status | output | 5 | {break, framing, parity, overrun, data-ready} |

## Verification
Two events can fall in the same clock cycle: the holding register being loaded at the end of a frame, and a data-read strobe from the host. To provoke the collision, the bench leaves an unread byte in the holding register and then sends a second frame. During that frame it fires a single read pulse, sweeping the pulse's offset over a window that straddles the end of the frame. Each trial is judged from the port values seen just before and just after the pulse, which show whether the read came before, with or after the load. The resulting overrun and data-ready values must match that case, and the sweep must hit the same-cycle case at least once.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
package uart_rx_pkg;

  localparam int WORD_MAX = 8;

  // Line-control layout: bit positions match the lcr input
  typedef struct packed {
    logic       stick;
    logic       even_sel;
    logic       par_en;
    logic       two_stop;
    logic [1:0] wlen;
  } fmt_t;

  typedef struct packed {
    logic [WORD_MAX-1:0] data;
    logic                perr;
    logic                ferr;
    logic                brk;
  } rx_res_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2, S_HOLD_LOW
  } rx_state_t;

  function automatic logic [3:0] word_bits(input logic [1:0] wlen);
    return 4'd5 + {2'b00, wlen};
  endfunction

  // Parity bit a correct transmitter sends for a zero-extended word
  function automatic logic want_parity(input logic [WORD_MAX-1:0] d, input fmt_t f);
    if (f.stick) return ~f.even_sel;
    return (^d) ^ ~f.even_sel;
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
`timescale 1ns/1ps
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  // Resets to the idle (high) level so no false start after reset
  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
`timescale 1ns/1ps
module rx_frame_fsm
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    tick,
  input  logic    line,
  input  fmt_t    fmt,
  output logic    done,
  output rx_res_t res
);
  localparam int CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVS / 2 - 1);

  rx_state_t           st;
  logic [CNT_W-1:0]    cnt;
  logic [2:0]          idx;
  logic [WORD_MAX-1:0] sr;
  fmt_t                fmt_q;
  logic                pbit;
  logic                stop1_q;
  logic                seen_high;

  logic [2:0] last_idx;
  logic       ferr_now;
  logic       finish;

  assign last_idx = 3'(word_bits(fmt_q.wlen) - 4'd1);
  assign ferr_now = (st == S_STOP1) ? ~line : ~stop1_q;
  assign finish   = tick && (cnt == LAST_CNT) &&
                    (((st == S_STOP1) && !fmt_q.two_stop) || (st == S_STOP2));

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      cnt       <= '0;
      idx       <= '0;
      sr        <= '0;
      fmt_q     <= '0;
      pbit      <= 1'b0;
      stop1_q   <= 1'b1;
      seen_high <= 1'b0;
      done      <= 1'b0;
      res       <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (tick && !line) begin
            st        <= S_START;
            cnt       <= '0;
            idx       <= '0;
            sr        <= '0;
            seen_high <= 1'b0;
            fmt_q     <= fmt;
          end
        end
        S_START: begin
          if (tick) begin
            if (cnt == MID_CNT) begin
              cnt <= '0;
              st  <= line ? S_IDLE : S_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        S_DATA, S_PAR, S_STOP1, S_STOP2: begin
          if (tick) begin
            if (cnt != LAST_CNT) begin
              cnt <= cnt + 1'b1;
            end else begin
              cnt       <= '0;
              seen_high <= seen_high | line;
              case (st)
                S_DATA: begin
                  sr[idx] <= line;
                  idx     <= idx + 1'b1;
                  if (idx == last_idx) st <= fmt_q.par_en ? S_PAR : S_STOP1;
                end
                S_PAR: begin
                  pbit <= line;
                  st   <= S_STOP1;
                end
                S_STOP1: begin
                  stop1_q <= line;
                  if (fmt_q.two_stop) st <= S_STOP2;
                end
                default: ;
              endcase
              if (finish) begin
                done     <= 1'b1;
                res.data <= sr;
                res.perr <= fmt_q.par_en && (pbit != want_parity(sr, fmt_q));
                res.ferr <= ferr_now;
                res.brk  <= ~(seen_high | line);
                st       <= line ? S_IDLE : S_HOLD_LOW;
              end
            end
          end
        end
        S_HOLD_LOW: begin
          if (tick && line) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R3
  AST_SHORT_WORD_ZERO: assert property (@(posedge clk) disable iff (rst)
    done |-> ((res.data >> word_bits(fmt_q.wlen)) == '0)); // R4
  AST_BREAK_HAS_FE: assert property (@(posedge clk) disable iff (rst)
    (done && res.brk) |-> res.ferr); // R7
endmodule

// File: rtl/rx_hold_reg.sv
`timescale 1ns/1ps
module rx_hold_reg
  import uart_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                done,
  input  rx_res_t             res,
  input  logic                rd_data,
  input  logic                rd_status,
  output logic [WORD_MAX-1:0] data_q,
  output logic [4:0]          status_q
);
  logic dr, ovr, pe, fe, bi;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      dr     <= 1'b0;
      ovr    <= 1'b0;
      pe     <= 1'b0;
      fe     <= 1'b0;
      bi     <= 1'b0;
    end else if (done) begin
      data_q <= res.data;
      dr     <= 1'b1;
      ovr    <= (ovr & ~rd_status) | (dr & ~rd_data);
      pe     <= (pe  & ~rd_status) | res.perr;
      fe     <= (fe  & ~rd_status) | res.ferr;
      bi     <= (bi  & ~rd_status) | res.brk;
    end else begin
      if (rd_data) dr <= 1'b0;
      if (rd_status) begin
        ovr <= 1'b0;
        pe  <= 1'b0;
        fe  <= 1'b0;
        bi  <= 1'b0;
      end
    end
  end

  assign status_q = {bi, fe, pe, ovr, dr};

  AST_READY_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    done |=> dr); // R8
  AST_READ_CLEARS_READY: assert property (@(posedge clk) disable iff (rst)
    (rd_data && !done) |=> !dr); // R8
  AST_OVERRUN_ON_UNREAD: assert property (@(posedge clk) disable iff (rst)
    (done && dr && !rd_data) |=> ovr); // R9
  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (rd_status && !done) |=> !(ovr || pe || fe || bi)); // R10
  AST_STATUS_KEEPS_READY: assert property (@(posedge clk) disable iff (rst)
    (rd_status && !rd_data && !done && dr) |=> dr); // R10
  AST_SAME_CYCLE_READ: assert property (@(posedge clk) disable iff (rst)
    (done && rd_data && !ovr) |=> (dr && !ovr)); // R11
endmodule

// File: rtl/uart_rx_engine.sv
`timescale 1ns/1ps
module uart_rx_engine
  import uart_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       rxd,
  input  logic [5:0] lcr,
  input  logic       rd_data,
  input  logic       rd_status,
  output logic [7:0] rx_data,
  output logic [4:0] rx_status
);
  logic    line_s;
  logic    done;
  rx_res_t res;
  fmt_t    fmt_in;

  assign fmt_in = fmt_t'(lcr);

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (rxd),
    .dout(line_s)
  );

  rx_frame_fsm #(.OVS(OVS)) u_fsm (
    .clk (clk),
    .rst (rst),
    .tick(tick),
    .line(line_s),
    .fmt (fmt_in),
    .done(done),
    .res (res)
  );

  rx_hold_reg u_hold (
    .clk      (clk),
    .rst      (rst),
    .done     (done),
    .res      (res),
    .rd_data  (rd_data),
    .rd_status(rd_status),
    .data_q   (rx_data),
    .status_q (rx_status)
  );
endmodule

// File: tb/uart_rx_engine_bench.sv
`timescale 1ns/1ps
module uart_rx_engine_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       rxd = 1'b1;
  logic [5:0] lcr = 6'h03;
  logic       rd_data = 1'b0;
  logic       rd_status = 1'b0;
  logic [7:0] rx_data;
  logic [4:0] rx_status;

  int total = 0;
  int bad = 0;
  int tick_div = 1;
  int tcnt = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  uart_rx_engine u_uart_rx_engine (
    .clk(clk), .rst(rst), .tick(tick), .rxd(rxd), .lcr(lcr),
    .rd_data(rd_data), .rd_status(rd_status),
    .rx_data(rx_data), .rx_status(rx_status)
  );

  always @(negedge clk) begin
    if (tcnt >= tick_div - 1) begin tcnt <= 0; tick <= 1'b1; end
    else begin tcnt <= tcnt + 1; tick <= 1'b0; end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nbits(input logic [5:0] l);
    return 5 + int'(l[1:0]);
  endfunction

  function automatic logic [7:0] mask(input logic [7:0] d, input logic [5:0] l);
    return d & 8'((32'd1 << nbits(l)) - 1);
  endfunction

  function automatic logic par_of(input logic [7:0] d, input logic [5:0] l);
    if (l[5]) return ~l[4];
    return (^mask(d, l)) ^ ~l[4];
  endfunction

  task automatic drive_frame(input logic [7:0] d, input logic [5:0] l,
                             input bit flip_par, input bit low_stop);
    int bc;
    bc = 16 * tick_div;
    rxd = 1'b0; wait_cyc(bc);
    for (int i = 0; i < nbits(l); i++) begin rxd = d[i]; wait_cyc(bc); end
    if (l[3]) begin rxd = par_of(d, l) ^ flip_par; wait_cyc(bc); end
    rxd = ~low_stop; wait_cyc(bc);
    if (l[2]) begin rxd = 1'b1; wait_cyc(bc); end
    rxd = 1'b1;
  endtask

  task automatic clear_all();
    rd_data = 1'b1; rd_status = 1'b1; wait_cyc(1);
    rd_data = 1'b0; rd_status = 1'b0; wait_cyc(1);
  endtask

  task automatic run_frame(input logic [7:0] d, input logic [5:0] l,
                           input bit flip_par, input bit low_stop, input string req);
    logic [7:0] md;
    logic pe, fe, bi, sentp;
    md    = mask(d, l);
    sentp = par_of(d, l) ^ flip_par;
    pe    = l[3] && flip_par;
    fe    = low_stop;
    bi    = low_stop && !l[2] && (md == 8'h00) && (!l[3] || !sentp);
    lcr = l;
    drive_frame(d, l, flip_par, low_stop);
    wait_cyc(16 * tick_div);
    chk({req, " data"}, int'(rx_data), int'(md));
    chk({req, " status"}, int'(rx_status), int'({bi, fe, pe, 1'b0, 1'b1}));
    clear_all();
    chk({req, " R8 R10 cleared"}, int'(rx_status), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] pre_d, post_d;
    logic post_dr;
    int hits;
    void'($urandom(32'h5eed_1234));
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(2);
    chk("R1 reset data", int'(rx_data), 0);
    chk("R1 reset status", int'(rx_status), 0);

    // R2: short low pulse is a glitch
    rxd = 1'b0; wait_cyc(4); rxd = 1'b1; wait_cyc(200);
    chk("R2 glitch status", int'(rx_status), 0);
    chk("R2 glitch data", int'(rx_data), 0);
    run_frame(8'h96, 6'h03, 0, 0, "R2 after glitch");

    // R4: short word zero-extended
    run_frame(8'hFF, 6'h00, 0, 0, "R4 5-bit");
    run_frame(8'hFF, 6'h02, 0, 0, "R4 7-bit");
    // R5: even, odd and stick parity
    run_frame(8'h37, 6'h1B, 0, 0, "R5 even ok");
    run_frame(8'h37, 6'h0B, 1, 0, "R5 odd bad");
    run_frame(8'hA5, 6'h3B, 0, 0, "R5 stick zero ok");
    run_frame(8'hA5, 6'h3B, 1, 0, "R5 stick zero bad");
    run_frame(8'h5A, 6'h2B, 0, 0, "R5 stick one ok");
    // R6: two stop bits, framing error
    run_frame(8'h3C, 6'h07, 0, 0, "R6 two stops");
    run_frame(8'h3C, 6'h07, 0, 1, "R6 low first stop");
    run_frame(8'h81, 6'h03, 0, 1, "R6 framing one stop");
    // R3: slower tick spacing
    tick_div = 3;
    run_frame(8'hC3, 6'h03, 0, 0, "R3 tick every 3");
    tick_div = 1;

    // R7: break, 8 data + even parity + 1 stop all low
    lcr = 6'h1B;
    rxd = 1'b0; wait_cyc(11 * 16); rxd = 1'b1; wait_cyc(32);
    chk("R7 break data", int'(rx_data), 0);
    chk("R7 break status", int'(rx_status), 'h19);
    clear_all();
    run_frame(8'h42, 6'h03, 0, 0, "R7 after break");

    // R9 / R10 / R8: overrun sequence
    lcr = 6'h03;
    drive_frame(8'h11, 6'h03, 0, 0); wait_cyc(16);
    drive_frame(8'h22, 6'h03, 0, 0); wait_cyc(16);
    chk("R9 overrun data", int'(rx_data), 'h22);
    chk("R9 overrun status", int'(rx_status), 'h03);
    rd_status = 1'b1; wait_cyc(1); rd_status = 1'b0; wait_cyc(1);
    chk("R10 status read keeps ready", int'(rx_status), 'h01);
    rd_data = 1'b1; wait_cyc(1); rd_data = 1'b0; wait_cyc(1);
    chk("R8 data read clears ready", int'(rx_status), 'h00);

    // R12: format change mid-frame ignored
    lcr = 6'h03;
    fork
      drive_frame(8'hC5, 6'h03, 0, 0);
      begin wait_cyc(40); lcr = 6'h00; end
    join
    wait_cyc(16);
    chk("R12 latched data", int'(rx_data), 'hC5);
    chk("R12 latched status", int'(rx_status), 'h01);
    clear_all();

    // R11: sweep a read pulse across frame completion
    hits = 0;
    for (int off = 140; off < 175; off++) begin
      clear_all();
      lcr = 6'h03;
      drive_frame(8'h5A, 6'h03, 0, 0); wait_cyc(16);
      fork
        drive_frame(8'hA7, 6'h03, 0, 0);
        begin
          wait_cyc(off);
          pre_d = rx_data; rd_data = 1'b1; wait_cyc(1);
          rd_data = 1'b0; post_d = rx_data; post_dr = rx_status[0];
        end
      join
      wait_cyc(16);
      chk("R11 data", int'(rx_data), 'hA7);
      if (pre_d == 8'hA7) begin
        chk("R11 late read overrun", int'(rx_status), 'h02);
      end else begin
        if (post_d == 8'hA7 && post_dr) hits++;
        chk("R11 early or same-cycle read", int'(rx_status), 'h01);
      end
    end
    chk("R11 same-cycle case reached", int'(hits > 0), 1);
    clear_all();

    // Random frames, R3 R4 R5 R6 R7
    for (int k = 0; k < 30; k++) begin
      logic [5:0] l;
      logic [7:0] d;
      bit fp, ls;
      tick_div = 1 + (k % 3);
      l  = 6'($urandom);
      d  = 8'($urandom);
      fp = l[3] && ($urandom % 4 == 0);
      ls = ($urandom % 5 == 0);
      if (k % 10 == 9) begin d = 8'h00; ls = 1; end
      run_frame(d, l, fp, ls, "R3 R4 R5 R6 R7 random");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule